// File: doc/BRIEF.md
# Three-Sample Bang-Bang Phase Decision Logic

This block is the digital decision stage of a clock-and-data recovery loop that samples each received bit three times. On every bit period it is handed three already-registered samples: `samp_mid` taken in the centre of the current bit, `samp_edge` taken close to the boundary with the following bit, and `samp_next` taken in the centre of that following bit. From the three it decides whether the recovery clock is early, late, or whether no decision can be made. It then issues a single-cycle speed-up or slow-down pulse to the oscillator control path.

Alongside the correction pulses it retimes the eye-centre sample as the recovered data bit. It flags the case where both centre samples agree but the edge sample disagrees with them, which points to a likely bit error. It also strobes whenever a data transition is seen, for downstream activity or run-length monitors. An acquisition aid, such as a frequency window detector, can hold `corr_inhibit` high to silence the correction pulses while it pulls the oscillator into range. Corrections are pure binary: one nudge of fixed size per pulse, with no magnitude.

Top module: `bbpd_core`

## Requirements
- R1: When `samp_mid` equals `samp_next` (no transition), neither `pd_up` nor `pd_dn` is high in the following cycle, whatever `samp_edge` holds.
- R2: When `samp_edge` equals `samp_mid` but differs from `samp_next` (clock early) and `corr_inhibit` is low, `pd_dn` is high for exactly the following cycle and `pd_up` stays low.
- R3: When `samp_edge` equals `samp_next` but differs from `samp_mid` (clock late) and `corr_inhibit` is low, `pd_up` is high for exactly the following cycle and `pd_dn` stays low.
- R4: `data_out` equals the `samp_mid` value presented one clock earlier.
- R5: When `samp_mid` equals `samp_next` and `samp_edge` differs from both, `err_evt` is high for the following cycle and no correction is issued. In every other case `err_evt` is low.
- R6: While `corr_inhibit` is high, `pd_up` and `pd_dn` are low in the following cycle. `data_out`, `err_evt` and `trans_evt` behave as if the inhibit were low.
- R7: `pd_up` and `pd_dn` are never high in the same cycle.
- R8: `trans_evt` is high in the cycle after a triplet whose `samp_mid` differs from `samp_next`, and low otherwise, independent of `corr_inhibit`.
- R9: A clock edge with `rst_n` low (synchronous, active low) drives all five outputs to 0 for the following cycle, whatever the sample inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one edge per bit period |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_mid | input | 1 | Registered sample at the centre of the current bit |
| samp_edge | input | 1 | Registered sample near the following bit boundary |
| samp_next | input | 1 | Registered sample at the centre of the following bit |
| corr_inhibit | input | 1 | High suppresses correction pulses (acquisition aid) |
| pd_up | output | 1 | Speed-up pulse, one cycle per late decision |
| pd_dn | output | 1 | Slow-down pulse, one cycle per early decision |
| data_out | output | 1 | Retimed recovered data bit |
| err_evt | output | 1 | Suspected bit-error strobe |
| trans_evt | output | 1 | Data transition strobe |

## Verification
The properties assume that the three sample inputs and the inhibit are stable, known values at every rising edge while reset is released. They also assume that reset is held through at least one edge before the first check. The bench drives all inputs only on falling edges and holds reset low from time zero. It walks every one of the sixteen sample and inhibit combinations, then a long pseudo-random stream, and then a reset applied with every input high. In this way each decision branch is reached from varied preceding states.

// File: rtl/bbpd_pkg.sv
// Package bbpd_pkg
// Shared types for the three-sample phase decision logic.
// Assumes: one decision per clock, samples are single bits.
package bbpd_pkg;

    // Verdict of one sample triplet before any gating.
    typedef enum logic [1:0] {
        VERDICT_QUIET   = 2'd0,  // no transition, edge sample consistent
        VERDICT_SLOW    = 2'd1,  // clock early: slow down
        VERDICT_FAST    = 2'd2,  // clock late: speed up
        VERDICT_SUSPECT = 2'd3   // no transition, edge sample contradicts
    } verdict_e;

    // Flags presented to the output register stage.
    typedef struct packed {
        logic up;
        logic dn;
        logic err;
        logic trans;
        logic data;
    } pd_flags_t;

    localparam int unsigned FLAG_W = $bits(pd_flags_t);

endpackage

// File: rtl/bbpd_classify.sv
// Module bbpd_classify
// Combinational decision on one sample triplet (centre, edge, next centre).
// Assumes: samples are settled, registered values; no state is kept here.
module bbpd_classify
    import bbpd_pkg::*;
(
    input  logic     mid_i,
    input  logic     edge_i,
    input  logic     next_i,
    output verdict_e verdict_o,
    output logic     trans_o
);

    logic saw_trans;
    logic edge_eq_mid;

    // Derive the comparisons the decision table is built on.
    always_comb begin
        saw_trans   = mid_i ^ next_i;
        edge_eq_mid = ~(edge_i ^ mid_i);
    end

    // Map the comparisons onto a verdict.
    always_comb begin
        if (!saw_trans) begin
            verdict_o = edge_eq_mid ? VERDICT_QUIET : VERDICT_SUSPECT;
        end else begin
            verdict_o = edge_eq_mid ? VERDICT_SLOW : VERDICT_FAST;
        end
        trans_o = saw_trans;
    end

endmodule

// File: rtl/bbpd_gate.sv
// Module bbpd_gate
// Turns a verdict into flag bits and applies the correction inhibit.
// Assumes: inhibit affects only up/down; error, transition and data pass.
module bbpd_gate
    import bbpd_pkg::*;
(
    input  verdict_e  verdict_i,
    input  logic      trans_i,
    input  logic      data_i,
    input  logic      inhibit_i,
    output pd_flags_t flags_o
);

    // Decode the verdict and mask corrections under inhibit.
    always_comb begin
        flags_o       = '0;
        flags_o.data  = data_i;
        flags_o.trans = trans_i;
        unique case (verdict_i)
            VERDICT_SLOW:    flags_o.dn  = ~inhibit_i;
            VERDICT_FAST:    flags_o.up  = ~inhibit_i;
            VERDICT_SUSPECT: flags_o.err = 1'b1;
            default:         flags_o.err = 1'b0;
        endcase
    end

endmodule

// File: rtl/bbpd_outreg.sv
// Module bbpd_outreg
// Output register stage: one clock of latency, synchronous active-low clear.
// Assumes: flags_i is a complete next-state for every output bit.
module bbpd_outreg
    import bbpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pd_flags_t flags_i,
    output pd_flags_t flags_o
);

    // Capture the flags each bit period, clearing them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= flags_i;
        end
    end

endmodule

// File: rtl/bbpd_core.sv
// Module bbpd_core
// Three-sample bang-bang phase decision logic: classifies each triplet,
// gates corrections with the acquisition inhibit, registers all outputs.
// Assumes: one triplet per clock; all outputs lag the inputs by one clock.
module bbpd_core
    import bbpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic samp_mid,
    input  logic samp_edge,
    input  logic samp_next,
    input  logic corr_inhibit,
    output logic pd_up,
    output logic pd_dn,
    output logic data_out,
    output logic err_evt,
    output logic trans_evt
);

    verdict_e  verdict;
    logic      trans_now;
    pd_flags_t flags_next;
    pd_flags_t flags_q;

    bbpd_classify u_classify (
        .mid_i     (samp_mid),
        .edge_i    (samp_edge),
        .next_i    (samp_next),
        .verdict_o (verdict),
        .trans_o   (trans_now)
    );

    bbpd_gate u_gate (
        .verdict_i (verdict),
        .trans_i   (trans_now),
        .data_i    (samp_mid),
        .inhibit_i (corr_inhibit),
        .flags_o   (flags_next)
    );

    bbpd_outreg u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_next),
        .flags_o (flags_q)
    );

    // Fan the registered flags out to the ports.
    always_comb begin
        pd_up     = flags_q.up;
        pd_dn     = flags_q.dn;
        data_out  = flags_q.data;
        err_evt   = flags_q.err;
        trans_evt = flags_q.trans;
    end

endmodule

// File: rtl/bbpd_core_chk.sv
// Module bbpd_core_chk
// Port-level properties of bbpd_core, attached with bind below.
// Assumes: inputs are known at every rising edge while rst_n is high.
module bbpd_core_chk (
    input logic clk,
    input logic rst_n,
    input logic samp_mid,
    input logic samp_edge,
    input logic samp_next,
    input logic corr_inhibit,
    input logic pd_up,
    input logic pd_dn,
    input logic data_out,
    input logic err_evt,
    input logic trans_evt
);

    assert_quiet_no_corr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_mid == samp_next) |=> (!pd_up && !pd_dn));

    assert_early_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_inhibit && samp_edge == samp_mid && samp_edge != samp_next)
        |=> (pd_dn && !pd_up));

    assert_late_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_inhibit && samp_edge == samp_next && samp_edge != samp_mid)
        |=> (pd_up && !pd_dn));

    assert_data_retime_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (data_out == $past(samp_mid)));

    assert_err_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_mid == samp_next && samp_edge != samp_mid) |=> (err_evt && !pd_up && !pd_dn));

    assert_err_only_suspect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_mid == samp_next && samp_edge != samp_mid) |=> !err_evt);

    assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        corr_inhibit |=> (!pd_up && !pd_dn));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_up, pd_dn}));

    assert_trans_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (trans_evt == ($past(samp_mid) != $past(samp_next))));

endmodule

bind bbpd_core bbpd_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_mid     (samp_mid),
    .samp_edge    (samp_edge),
    .samp_next    (samp_next),
    .corr_inhibit (corr_inhibit),
    .pd_up        (pd_up),
    .pd_dn        (pd_dn),
    .data_out     (data_out),
    .err_evt      (err_evt),
    .trans_evt    (trans_evt)
);

// File: tb/bbpd_core_test.sv
// Bench for bbpd_core: behavioural model compared every clock at negedge.
module bbpd_core_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0, t = 1'b0, b = 1'b0, inh = 1'b0;
    logic pd_up, pd_dn, data_out, err_evt, trans_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected outputs for the next comparison.
    logic e_up = 1'b0, e_dn = 1'b0, e_data = 1'b0, e_err = 1'b0, e_trans = 1'b0;

    always #5 clk = ~clk;

    bbpd_core uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_mid     (a),
        .samp_edge    (t),
        .samp_next    (b),
        .corr_inhibit (inh),
        .pd_up        (pd_up),
        .pd_dn        (pd_dn),
        .data_out     (data_out),
        .err_evt      (err_evt),
        .trans_evt    (trans_evt)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare outputs against the model's prediction for this cycle.
    task automatic compare(input bit in_reset);
        if (in_reset) begin
            chk(pd_up, 1'b0, "R9 pd_up");
            chk(pd_dn, 1'b0, "R9 pd_dn");
            chk(data_out, 1'b0, "R9 data_out");
            chk(err_evt, 1'b0, "R9 err_evt");
            chk(trans_evt, 1'b0, "R9 trans_evt");
        end else begin
            chk(pd_up, e_up, "R3/R1/R6 pd_up");
            chk(pd_dn, e_dn, "R2/R1/R6 pd_dn");
            chk(pd_up & pd_dn, 1'b0, "R7 exclusive");
            chk(data_out, e_data, "R4 data_out");
            chk(err_evt, e_err, "R5 err_evt");
            chk(trans_evt, e_trans, "R8 trans_evt");
        end
    endtask

    // Drive one triplet at a negedge, predict, then compare at the next negedge.
    task automatic step(input logic na, input logic nt, input logic nb, input logic ni);
        bit was_reset;
        a = na; t = nt; b = nb; inh = ni;
        was_reset = !rst_n;
        e_trans = (na != nb);
        e_err   = (na == nb) && (nt != na);
        e_dn    = !ni && (na != nb) && (nt == na);
        e_up    = !ni && (na != nb) && (nt == nb);
        e_data  = na;
        @(negedge clk);
        compare(was_reset);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R9: outputs cleared while reset held with busy inputs
        step(1'b1, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        // Exhaustive walk of all triplets with and without inhibit (R1..R8)
        for (int i = 0; i < 16; i++) begin
            step(i[0], i[1], i[2], i[3]);
        end
        // Back-to-back identical late and early decisions (R2, R3 one-cycle pulses)
        repeat (3) step(1'b0, 1'b1, 1'b1, 1'b0);
        repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        // Pseudo-random stream
        for (int n = 0; n < 600; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0], r[1], r[2], (n > 300) ? r[3] : 1'b0);
        end
        // R9: reset mid-stream with every input high
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule